// File: doc/BRIEF.md
# Interrupt Acceptance and Blocking Gate

This block sits beside the retire stage of a small pipelined CPU. On every instruction boundary it decides whether one of the maskable interrupt sources may be taken. Requests are caught in a pending register. A request is eligible only when its mask bit is set and the global disable flag is clear. Two classes of retired instruction open a short blocking window, counted in retired instructions. The first is the instruction that clears the disable flag. The second is a subroutine or interrupt return. Because of this window, a return placed directly after re-enabling always completes before a new interrupt is accepted.

Once a source has been accepted, the gate raises a drain request and holds it. When the pipeline reports that it is empty, the gate emits a one-cycle take strobe together with the chosen source index. In that same edge it sets the disable flag and clears the pending bit of the taken source. The CPU supplies each retired instruction's class and a protection tag. The gate uses that tag to lengthen the window after a return.

Top module: `irq_gate`

## Requirements
- R1: While `rst` is high, `drain_o` and `take_o` go low on the next clock edge. The disable flag is set, the pending register is emptied and the blocking window is closed, so no source is accepted until an enable instruction retires.
- R2: A source is accepted only if its `irq_mask_i` bit is set and the disable flag is clear. Masked pending sources are skipped.
- R3: A retire with class 2'b01 (enable) clears the disable flag. Acceptance then waits until EN_WIN further instructions have retired (default 1), so both the enable and the instruction after it retire first.
- R4: A retire with class 2'b10 (return) blocks acceptance until RET_WIN further instructions have retired (default 1).
- R5: A plain or disable-class retire inside an open window that carries `retire_prot_i` lengthens the window by PROT_EXTRA retires (default 1).
- R6: `drain_o` rises on the edge after the cycle in which acceptance is decided. In any cycle where `drain_o` and `pipe_empty_i` are both high, `take_o` is high on the next edge and `drain_o` falls on that same edge.
- R7: Among eligible pending sources, the lowest index wins. `src_o` is loaded with that index when `drain_o` rises.
- R8: A request pulse is held as pending until it is taken. The taken source's pending bit is cleared by the take, unless a new request for the same source arrives in that cycle.
- R9: Taking an interrupt sets the disable flag on the same edge that raises `take_o`.
- R10: A retire with class 2'b11 (disable) sets the disable flag. No acceptance is decided in a cycle in which any non-plain class retires.
- R11: `take_o` lasts one cycle. Once `drain_o` is high, it stays high with `src_o` unchanged until the take, whatever happens to the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | N_SRC | Request pulses, one per source |
| irq_mask_i | input | N_SRC | Per-source enable mask |
| retire_i | input | 1 | An instruction retired this cycle |
| retire_cls_i | input | 2 | Class of the retired instruction: 00 plain, 01 enable, 10 return, 11 disable |
| retire_prot_i | input | 1 | Retired instruction needs extra pipeline protection |
| pipe_empty_i | input | 1 | No instruction is in flight |
| drain_o | output | 1 | Request to finish in-flight instructions before the vector |
| take_o | output | 1 | One-cycle interrupt take strobe |
| src_o | output | $clog2(N_SRC) | Index of the accepted source |

## Verification
The hardest case to reach is a protection-tagged retire that lands inside a return window while an unmasked source is pending and the disable flag is already clear. Random traffic seldom lines those four conditions up. The directed part stages it deliberately. It holds the mask at zero while a request is latched and the flag is cleared. It then opens the mask in the same cycle that the return retires, so the extension is the only thing still holding the take off. A long random phase follows, compared each cycle against a bench model, and mixes all four classes with drains that are interrupted by mask changes.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'b00,
    CLS_ENABLE  = 2'b01,
    CLS_RETURN  = 2'b10,
    CLS_DISABLE = 2'b11
  } instr_cls_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic             clr_en_i,
  input  logic [IW-1:0]    clr_idx_i,
  output logic [N_SRC-1:0] pend_o
);

  // One flop per source; a fresh request beats the clear of the same bit.
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic hit;
    assign hit = clr_en_i && (clr_idx_i == IW'(g));
    always_ff @(posedge clk) begin
      if (rst)            pend_o[g] <= 1'b0;
      else if (req_i[g])  pend_o[g] <= 1'b1;
      else if (hit)       pend_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);

  // Prefix chain: a bit wins when no lower bit is set.
  logic [N_SRC:0] below;
  logic [N_SRC-1:0] win;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign win[g]     = vec_i[g] && !below[g];
    assign below[g+1] = below[g] || vec_i[g];
  end

  assign any_o = below[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (win[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irq_window.sv
module irq_window
  import irq_gate_pkg::*;
#(
  parameter int EN_WIN     = 1,
  parameter int RET_WIN    = 1,
  parameter int PROT_EXTRA = 1,
  localparam int TOP = max2(EN_WIN, RET_WIN) + PROT_EXTRA,
  localparam int CW  = $clog2(TOP + 1) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       retire_i,
  input  logic [1:0] cls_i,
  input  logic       prot_i,
  input  logic       take_i,
  output logic       dis_nxt_o,
  output logic       open_nxt_o,
  output logic       special_o
);

  localparam logic [CW:0] CMAX = {1'b0, {CW{1'b1}}};

  instr_cls_e cls;
  logic          dis_q;
  logic [CW-1:0] blk_q, blk_nxt;
  logic [CW:0]   ext;

  assign cls       = instr_cls_e'(cls_i);
  assign special_o = retire_i && (cls != CLS_PLAIN);

  always_comb begin
    blk_nxt = blk_q;
    ext     = '0;
    if (retire_i) begin
      case (cls)
        CLS_RETURN: blk_nxt = CW'(RET_WIN);
        CLS_ENABLE: blk_nxt = CW'(EN_WIN);
        default: begin
          if (blk_q != '0) begin
            ext = {1'b0, blk_q} - 1'b1 + (prot_i ? (CW+1)'(PROT_EXTRA) : '0);
            blk_nxt = (ext > CMAX) ? CMAX[CW-1:0] : ext[CW-1:0];
          end
        end
      endcase
    end
  end

  always_comb begin
    dis_nxt_o = dis_q;
    if (take_i)                                dis_nxt_o = 1'b1;
    else if (retire_i && cls == CLS_ENABLE)    dis_nxt_o = 1'b0;
    else if (retire_i && cls == CLS_DISABLE)   dis_nxt_o = 1'b1;
  end

  assign open_nxt_o = (blk_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= 1'b1;
      blk_q <= '0;
    end else begin
      dis_q <= dis_nxt_o;
      blk_q <= blk_nxt;
    end
  end

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_SRC      = 8,
  parameter int EN_WIN     = 1,
  parameter int RET_WIN    = 1,
  parameter int PROT_EXTRA = 1,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic [N_SRC-1:0] irq_mask_i,
  input  logic             retire_i,
  input  logic [1:0]       retire_cls_i,
  input  logic             retire_prot_i,
  input  logic             pipe_empty_i,
  output logic             drain_o,
  output logic             take_o,
  output logic [IW-1:0]    src_o
);

  logic [N_SRC-1:0] pend, cand;
  logic             any;
  logic [IW-1:0]    idx;
  logic             take_ev, start;
  logic             dis_nxt, open_nxt, special;

  assign take_ev = drain_o && pipe_empty_i;

  irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .req_i    (irq_req_i),
    .clr_en_i (take_ev),
    .clr_idx_i(src_o),
    .pend_o   (pend)
  );

  assign cand = pend & irq_mask_i;

  irq_prio #(.N_SRC(N_SRC)) u_prio (
    .vec_i(cand),
    .any_o(any),
    .idx_o(idx)
  );

  irq_window #(
    .EN_WIN    (EN_WIN),
    .RET_WIN   (RET_WIN),
    .PROT_EXTRA(PROT_EXTRA)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .retire_i  (retire_i),
    .cls_i     (retire_cls_i),
    .prot_i    (retire_prot_i),
    .take_i    (take_ev),
    .dis_nxt_o (dis_nxt),
    .open_nxt_o(open_nxt),
    .special_o (special)
  );

  // Acceptance is decided on the post-retire view of flag and window.
  assign start = !drain_o && any && !dis_nxt && open_nxt && !special;

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_o <= 1'b0;
      take_o  <= 1'b0;
      src_o   <= '0;
    end else begin
      take_o <= take_ev;
      if (start) begin
        drain_o <= 1'b1;
        src_o   <= idx;
      end else if (take_ev) begin
        drain_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] irq_mask_i,
  input logic             retire_i,
  input logic [1:0]       retire_cls_i,
  input logic             pipe_empty_i,
  input logic             drain_o,
  input logic             take_o,
  input logic [IW-1:0]    src_o
);

  logic [N_SRC-1:0] mask_q;
  always_ff @(posedge clk) mask_q <= irq_mask_i;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!drain_o && !take_o));

  // R11
  take_once_chk: assert property (@(posedge clk) disable iff (rst) take_o |=> !take_o);

  // R6
  take_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (drain_o && pipe_empty_i) |=> (take_o && !drain_o));

  // R6
  take_needs_drain_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ($past(drain_o) && $past(pipe_empty_i)));

  // R11
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drain_o && !pipe_empty_i) |=> (drain_o && $stable(src_o)));

  // R2
  drain_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drain_o) |-> mask_q[src_o]);

  // R10
  special_block_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && retire_cls_i != 2'b00 && !drain_o) |=> !drain_o);

endmodule

bind irq_gate irq_gate_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_mask_i  (irq_mask_i),
  .retire_i    (retire_i),
  .retire_cls_i(retire_cls_i),
  .pipe_empty_i(pipe_empty_i),
  .drain_o     (drain_o),
  .take_o      (take_o),
  .src_o       (src_o)
);

// File: tb/sim_irq_gate.sv
`timescale 1ns/1ps
module sim_irq_gate;

  localparam int N  = 8;
  localparam int IW = 3;
  localparam int EW = 1, RW = 1, PE = 1;
  localparam logic [1:0] P = 2'b00, EN = 2'b01, RT = 2'b10, DS = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, mask = '0;
  logic retire = 1'b0, prot = 1'b0, empty = 1'b0;
  logic [1:0] cls = P;
  logic drain, take;
  logic [IW-1:0] src;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_gate #(.N_SRC(N), .EN_WIN(EW), .RET_WIN(RW), .PROT_EXTRA(PE)) u0 (
    .clk(clk), .rst(rst), .irq_req_i(req), .irq_mask_i(mask),
    .retire_i(retire), .retire_cls_i(cls), .retire_prot_i(prot),
    .pipe_empty_i(empty), .drain_o(drain), .take_o(take), .src_o(src)
  );

  // Bench model, written from the requirements
  logic [N-1:0] m_pend;
  logic m_dis, m_drain, m_take;
  int m_blk;
  logic [IW-1:0] m_src;

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_dis = 1'b1; m_drain = 1'b0; m_take = 1'b0; m_blk = 0; m_src = '0;
  endtask

  task automatic model_step();
    logic tk, n_dis, st;
    logic [N-1:0] n_pend;
    int n_blk;
    tk = m_drain && empty;
    n_pend = m_pend;
    if (tk) n_pend[m_src] = 1'b0;
    n_pend = n_pend | req;
    n_dis = m_dis;
    if (tk) n_dis = 1'b1;
    else if (retire && cls == EN) n_dis = 1'b0;
    else if (retire && cls == DS) n_dis = 1'b1;
    n_blk = m_blk;
    if (retire) begin
      if (cls == RT) n_blk = RW;
      else if (cls == EN) n_blk = EW;
      else if (m_blk > 0) n_blk = m_blk - 1 + (prot ? PE : 0);
    end
    st = !m_drain && ((m_pend & mask) != 0) && !n_dis && (n_blk == 0) && !(retire && cls != P);
    if (st) begin
      m_drain = 1'b1;
      m_src = IW'(lowest(m_pend & mask));
    end else if (tk) m_drain = 1'b0;
    m_take = tk;
    m_pend = n_pend; m_dis = n_dis; m_blk = n_blk;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] mk, input logic rt,
                      input logic [1:0] cl, input logic pr, input logic em);
    req = rq; mask = mk; retire = rt; cls = cl; prot = pr; empty = em;
    model_step();
    @(negedge clk);
    chk("R6 drain", int'(drain), int'(m_drain));
    chk("R6 take", int'(take), int'(m_take));
    if (m_drain || m_take) chk("R7 src", int'(src), int'(m_src));
  endtask

  task automatic idle(input logic [N-1:0] mk);
    step('0, mk, 1'b0, P, 1'b0, 1'b0);
  endtask

  task automatic open_gate(input logic [N-1:0] mk);
    step('0, mk, 1'b1, EN, 1'b0, 1'b0);
    step('0, mk, 1'b1, P, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 drain after reset", int'(drain), 0);
    chk("R1 take after reset", int'(take), 0);

    // R1: flag starts set, a pending source waits
    step(8'h08, 8'hFF, 0, P, 0, 0);
    idle(8'hFF); idle(8'hFF);
    chk("R1 disabled from reset", int'(drain), 0);

    // R3: enable then one more retire
    step('0, 8'hFF, 1, EN, 0, 0);
    chk("R3 enable retire", int'(drain), 0);
    idle(8'hFF);
    chk("R3 window holds without retire", int'(drain), 0);
    step('0, 8'hFF, 1, P, 0, 0);
    chk("R3 accepted after next retire", int'(drain), 1);
    idle(8'hFF);
    chk("R11 drain held", int'(drain), 1);
    step('0, 8'hFF, 0, P, 0, 1);
    chk("R6 take strobe", int'(take), 1);
    chk("R6 drain falls", int'(drain), 0);
    chk("R7 src three", int'(src), 3);
    idle(8'hFF);
    chk("R11 take single cycle", int'(take), 0);

    // R9 / R2
    step(8'h22, 8'h20, 0, P, 0, 0);
    idle(8'h20); idle(8'h20);
    chk("R9 flag set by take", int'(drain), 0);
    open_gate(8'h20);
    chk("R2 masked source skipped", int'(src), 5);
    step('0, 8'h20, 0, P, 0, 1);
    chk("R2 take five", int'(take), 1);

    // R8: held pending, re-request during take
    open_gate(8'hFF);
    chk("R8 held pending src", int'(src), 1);
    step(8'h02, 8'hFF, 0, P, 0, 1);
    chk("R8 take one", int'(take), 1);
    open_gate(8'hFF);
    chk("R8 request in take cycle kept", int'(drain), 1);
    step('0, 8'hFF, 0, P, 0, 1);
    open_gate(8'hFF);
    chk("R8 pending cleared", int'(drain), 0);

    // R7 and R11 commitment
    step(8'h44, 8'hFF, 0, P, 0, 0);
    chk("R7 latch cycle", int'(drain), 0);
    idle(8'hFF);
    chk("R7 lowest wins", int'(src), 2);
    step('0, 8'h00, 0, P, 0, 0);
    chk("R11 drain survives mask", int'(drain), 1);
    chk("R11 src stable", int'(src), 2);
    step('0, 8'h00, 0, P, 0, 1);
    chk("R11 committed take", int'(take), 1);

    // R4: return window (bit 6 still pending)
    open_gate(8'h00);
    step('0, 8'hFF, 1, RT, 0, 0);
    chk("R4 return cycle", int'(drain), 0);
    idle(8'hFF);
    chk("R4 blocked after return", int'(drain), 0);
    step('0, 8'hFF, 1, P, 0, 0);
    chk("R4 open after one retire", int'(drain), 1);
    chk("R4 src six", int'(src), 6);
    step('0, 8'hFF, 0, P, 0, 1);

    // R5: protection extension
    step(8'h01, 8'h00, 0, P, 0, 0);
    open_gate(8'h00);
    step('0, 8'hFF, 1, RT, 0, 0);
    step('0, 8'hFF, 1, P, 1, 0);
    chk("R5 extended window", int'(drain), 0);
    step('0, 8'hFF, 1, P, 0, 0);
    chk("R5 open after extension", int'(drain), 1);
    chk("R5 src zero", int'(src), 0);
    step('0, 8'hFF, 0, P, 0, 1);

    // R10: disable instruction
    step(8'h80, 8'h00, 0, P, 0, 0);
    open_gate(8'h00);
    step('0, 8'hFF, 1, DS, 0, 0);
    chk("R10 disable cycle", int'(drain), 0);
    idle(8'hFF);
    chk("R10 flag set", int'(drain), 0);
    open_gate(8'hFF);
    chk("R10 reenabled src", int'(src), 7);
    step('0, 8'hFF, 0, P, 0, 1);

    // Random phase against the model
    for (int k = 0; k < 5000; k++) begin
      logic [N-1:0] rq;
      logic [1:0] c;
      int w;
      rq = N'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 7) == 0) mask = N'($urandom);
      w = $urandom_range(0, 99);
      c = (w < 60) ? P : (w < 75) ? EN : (w < 90) ? RT : DS;
      step(rq, mask, 1'($urandom_range(0, 1)), c,
           1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 9) < 4));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

endmodule